// File: doc/BRIEF.md
# Collision Backoff Delay Timer

After a transmit collision on a shared half-duplex medium, a station has to wait a random whole number of slot times before it tries again, and the range of that random number grows with the number of collisions so far. This block does that wait. A one-cycle `start` pulse carries the collision count and a truncation setting. The block then draws a slot count from a free-running maximal-length LFSR and counts that many slots of `SLOT_BITS` bit-time ticks. When the count is used up it pulses `done`.

The exponent of the range is the smaller of the collision count and the truncation setting. A truncation setting above `MAX_EXP` is treated as `MAX_EXP`. Lowering the truncation point makes a station retry more aggressively after many collisions. A skip input bypasses the wait completely. The caller supplies the `bit_tick` strobe at one pulse per bit time. The drawn value is shown on `slot_draw` while the block waits.

Top module: `backoff_timer`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `slot_draw` is 0.
- R2: On an accepted `start`, the exponent k is min(`coll_cnt`, min(`trunc`, `MAX_EXP`)). `slot_draw` becomes a value from 0 to 2^k−1, taken from the low k bits of an LFSR that advances every clock and never holds all zeros.
- R3: With `coll_cnt` = 1, `slot_draw` is 0 or 1, and both values occur over repeated draws.
- R4: The truncation setting caps the range when it is below the collision count. A setting above `MAX_EXP` (default 10) caps the range at 2^`MAX_EXP`−1.
- R5: For a nonzero draw, `busy` is 1 from the cycle after `start` until `done`. `done` pulses in the cycle after the clock edge that samples the (`slot_draw`×`SLOT_BITS`)-th `bit_tick` counted after `start`. `SLOT_BITS` defaults to 512.
- R6: A zero draw (including `coll_cnt` = 0) gives `done` in the cycle after `start`, and `busy` stays 0.
- R7: With `skip` = 1 at `start`, `slot_draw` is 0 and `done` is 1 in the cycle after `start`, whatever the collision count is.
- R8: A `start` while `busy` is ignored. `slot_draw` is unchanged and `done` still comes after the original tick count.
- R9: Clock edges without `bit_tick` do not advance the wait.
- R10: `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a backoff (one-cycle pulse) |
| coll_cnt | input | 5 | Collisions so far for this frame |
| trunc | input | 4 | Exponent truncation point |
| skip | input | 1 | Bypass the backoff wait |
| bit_tick | input | 1 | One pulse per bit time |
| busy | output | 1 | Backoff wait in progress |
| done | output | 1 | One-cycle pulse: retry may begin |
| slot_draw | output | MAX_EXP | Slot count drawn for the current wait |

## Verification
`slot_draw`, `busy` and an immediate `done` are registered at the edge that samples `start`, so the bench reads them at the next falling edge. A nonzero wait ends one edge after the last counted tick. The bench drives each tick at a falling edge, counts it when the following edge has passed, and reads `done` at the falling edge after that. It requires the tick count at the first high `done` to equal `slot_draw` × 512 exactly, and it checks that `done` is low one cycle later. Range checks for large exponents read `slot_draw` right after `start`, then abort the long wait with a reset.

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int SLOT_BITS = 512,
  parameter int MAX_EXP   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [4:0]         coll_cnt,
  input  logic [3:0]         trunc,
  input  logic               skip,
  input  logic               bit_tick,
  output logic               busy,
  output logic               done,
  output logic [MAX_EXP-1:0] slot_draw
);
  localparam int BW = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);

  logic [15:0]        lfsr;
  logic [BW-1:0]      bitcnt;
  logic [MAX_EXP-1:0] slots_left, mask, mask_q, draw;
  int                 tr_eff, k;

  always_comb begin
    tr_eff = (int'(trunc) > MAX_EXP) ? MAX_EXP : int'(trunc);
    k      = (int'(coll_cnt) < tr_eff) ? int'(coll_cnt) : tr_eff;
  end

  assign mask  = ~({MAX_EXP{1'b1}} << k);
  assign draw  = lfsr[MAX_EXP-1:0] & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? TAPS : 16'h0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      slot_draw  <= '0;
      slots_left <= '0;
      mask_q     <= '0;
      bitcnt     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        bitcnt     <= '0;
        mask_q     <= mask;
        slot_draw  <= skip ? '0 : draw;
        slots_left <= skip ? '0 : draw;
        if (skip || draw == '0) done <= 1'b1;
        else                    busy <= 1'b1;
      end else if (busy && bit_tick) begin
        if (bitcnt == LAST_BIT) begin
          bitcnt <= '0;
          if (slots_left == MAX_EXP'(1)) begin
            slots_left <= '0;
            busy       <= 1'b0;
            done       <= 1'b1;
          end else begin
            slots_left <= slots_left - 1'b1;
          end
        end else begin
          bitcnt <= bitcnt + 1'b1;
        end
      end
    end
  end

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n) lfsr != 16'h0);
  assert_draw_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n) (slot_draw & ~mask_q) == '0);
  assert_skip_immediate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && skip |=> done && slot_draw == '0 && !busy);
  assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(slot_draw));
  assert_no_tick_no_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !bit_tick |=> !done && busy);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
endmodule

// File: tb/tb_backoff_timer.sv
module tb_backoff_timer;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, skip = 1'b0, bit_tick = 1'b0;
  logic [4:0] coll_cnt = '0;
  logic [3:0] trunc = 4'd10;
  logic busy, done;
  logic [9:0] slot_draw;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backoff_timer dut (.clk(clk), .rst_n(rst_n), .start(start), .coll_cnt(coll_cnt),
    .trunc(trunc), .skip(skip), .bit_tick(bit_tick), .busy(busy), .done(done),
    .slot_draw(slot_draw));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; bit_tick = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one full backoff; every: tick period in cycles; mid: tick count at which a second start is issued
  task automatic run(input int n, input int tr, input bit sk, input int every, input int mid,
                     input string req, output int r);
    int ticks, ph, lim;
    coll_cnt = 5'(n); trunc = 4'(tr); skip = sk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r = int'(slot_draw);
    if (r == 0) begin
      chk(done == 1'b1 && busy == 1'b0, req, int'(done), 1);
    end else begin
      chk(done == 1'b0 && busy == 1'b1, "R5", int'(busy), 1);
      ticks = 0; ph = 0; lim = r * SB;
      while (1) begin
        bit_tick = (ph % every) == 0;
        start = (mid > 0 && ticks == mid);
        ph++;
        @(negedge clk);
        start = 1'b0;
        if (bit_tick) ticks++;
        bit_tick = 1'b0;
        if (done || ticks > lim) break;
      end
      chk(ticks == lim && busy == 1'b0, req, ticks, lim);
      if (mid > 0) chk(int'(slot_draw) == r, "R8", int'(slot_draw), r);
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", int'(done), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(!done && !busy && slot_draw == '0, "R1", int'(slot_draw), 0);
  endtask

  task automatic t_first_collision();
    int r; bit s0 = 0, s1 = 0;
    for (int i = 0; i < 16; i++) begin
      run(1, 10, 1'b0, 1, 0, "R3", r);
      chk(r <= 1, "R3", r, 1);
      if (r == 0) s0 = 1; else s1 = 1;
      repeat (i % 3) @(negedge clk);
    end
    chk(s0 && s1, "R3", int'(s0) + int'(s1), 2);
  endtask

  task automatic t_exponent();
    int r;
    for (int i = 0; i < 8; i++) begin
      run(3, 10, 1'b0, 1, 0, "R5", r);
      chk(r <= 7, "R2", r, 7);
    end
  endtask

  task automatic t_trunc();
    int r, mx = 0;
    for (int i = 0; i < 8; i++) begin
      run(12, 2, 1'b0, 1, 0, "R4", r);
      chk(r <= 3, "R4", r, 3);
    end
    for (int i = 0; i < 12; i++) begin
      do_reset();
      repeat (i * 7 + 1) @(negedge clk);
      coll_cnt = 5'd15; trunc = 4'd15; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(int'(slot_draw) <= 1023, "R4", int'(slot_draw), 1023);
      if (int'(slot_draw) > mx) mx = int'(slot_draw);
    end
    chk(mx > 127, "R4", mx, 128);
    do_reset();
  endtask

  task automatic t_zero_and_skip();
    int r;
    run(0, 10, 1'b0, 1, 0, "R6", r);
    chk(r == 0, "R6", r, 0);
    run(6, 10, 1'b1, 1, 0, "R7", r);
    chk(r == 0, "R7", r, 0);
  endtask

  task automatic t_slow_tick();
    int r = 0;
    for (int i = 0; i < 12 && r == 0; i++) run(1, 10, 1'b0, 3, 0, "R9", r);
    chk(r == 1, "R9", r, 1);
  endtask

  task automatic t_start_busy();
    int r = 0;
    for (int i = 0; i < 12 && r == 0; i++) run(2, 10, 1'b0, 1, 100, "R8", r);
    chk(r != 0, "R8", r, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_first_collision();
    t_exponent();
    t_trunc();
    t_zero_and_skip();
    t_slow_tick();
    t_start_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule